// File: doc/BRIEF.md
# Edge-Latched Interrupt Flag Controller

This block gathers sixteen asynchronous interrupt sources into one interrupt request line for a host processor. Each source is brought into the clock domain through two flip-flops, and a rising transition on it sets a sticky pending flag. A mask register decides which pending flags may reach the output. A mask bit of 1 blocks its source and a 0 lets it through. The request line is registered. It is high while at least one pending flag has its mask bit clear.

The host uses a small synchronous register port with an address, a write strobe, write data and combinational read data. Software clears a flag by writing 0 in that bit position. A 1 in the write data leaves the flag as it is, so software can clear one source without disturbing the others. Flags still capture edges on masked sources. When such a source is unmasked, its pending event raises the request line.

The output stage is a two-state machine. In `IRQ_IDLE` the request line is low. When a pending unmasked flag exists, the transition `RAISE` moves the machine to `IRQ_RAISED`, where the request line is high. When no pending unmasked flag remains, the transition `DROP` returns it to `IRQ_IDLE`. In any other cycle the machine holds its state.

Top module: `edge_flag_irq_ctrl`

## Requirements
- R1: After reset the flag register reads 0x0000, the mask register reads 0x0700 (sources 8, 9 and 10 blocked), and `irq_out` is 0.
- R2: A rising edge on `src_in[i]` sets flag bit i within four clock cycles. The flag stays set after the source falls again.
- R3: A source held high, or a falling edge, sets no flag.
- R4: A write to offset 0x2 clears every flag bit whose write-data bit is 0. Flag bits written with 1 keep their value, and a write never sets a flag.
- R5: If a detected edge and a clearing write hit the same flag bit in the same cycle, the flag ends up set.
- R6: A write to offset 0xA replaces the mask register, and a read returns the stored value. A source whose mask bit is 1 cannot raise `irq_out`.
- R7: `irq_out` equals the OR over all bits of (flag AND NOT mask), delayed by one register stage.
- R8: Flags latch edges on masked sources. Clearing the mask bit of a pending flag raises `irq_out` on the cycle after the mask register changes.
- R9: A read at offset 0x2 returns the raw flags whatever the mask. A read at any offset other than 0x2 or 0xA returns 0.
- R10: A write to an offset other than 0x2 or 0xA changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 16 | Asynchronous interrupt sources |
| bus_addr | input | 4 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is R5, where a clearing write lands in the one cycle in which the synchroniser reports an edge. The stimulus raises a source on a falling clock edge and counts two clock edges through the synchroniser. It then presents an all-zero write to the flag offset so that the write is sampled on the same edge that latches the detected edge. The masked-pending path of R8 is reached by raising a blocked source, checking that the flag is set while the output stays low, and then clearing the mask bit.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;

    localparam int unsigned DEF_SRC    = 16;
    localparam int unsigned DEF_ADDR_W = 4;
endpackage

// File: rtl/eirq_edge_sync.sv
module eirq_edge_sync #(
    parameter int unsigned N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_in,
    output logic [N_SRC-1:0] rise_pulse
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_lane
        logic meta_q, stab_q, last_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
                last_q <= 1'b0;
            end else begin
                meta_q <= src_in[g];
                stab_q <= meta_q;
                last_q <= stab_q;
            end
        end

        assign rise_pulse[g] = stab_q & ~last_q;
    end
endmodule

// File: rtl/eirq_regfile.sv
module eirq_regfile #(
    parameter int unsigned      N_SRC    = 16,
    parameter int unsigned      ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] FLAG_OFS = 4'h2,
    parameter logic [ADDR_W-1:0] MASK_OFS = 4'hA,
    parameter logic [N_SRC-1:0]  MASK_RST = 16'h0700
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  rise_pulse,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [N_SRC-1:0]  bus_wdata,
    output logic [N_SRC-1:0]  bus_rdata,
    output logic [N_SRC-1:0]  flag_q,
    output logic [N_SRC-1:0]  mask_q
);
    logic             hit_flag, hit_mask;
    logic [N_SRC-1:0] keep_bits;

    assign hit_flag  = bus_we && (bus_addr == FLAG_OFS);
    assign hit_mask  = bus_we && (bus_addr == MASK_OFS);
    assign keep_bits = hit_flag ? bus_wdata : {N_SRC{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            mask_q <= MASK_RST;
        end else begin
            flag_q <= (flag_q & keep_bits) | rise_pulse;
            if (hit_mask) mask_q <= bus_wdata;
        end
    end

    always_comb begin
        if (bus_addr == FLAG_OFS)      bus_rdata = flag_q;
        else if (bus_addr == MASK_OFS) bus_rdata = mask_q;
        else                           bus_rdata = '0;
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_flag && rise_pulse == '0) |=> $stable(flag_q)); // R2
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_pulse != '0) |=> ((flag_q & $past(rise_pulse)) == $past(rise_pulse))); // R5
    AST_WRITE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_pulse == '0) |=> ((flag_q & ~$past(flag_q)) == '0)); // R4
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_mask |=> $stable(mask_q)); // R10
endmodule

// File: rtl/eirq_irq_fsm.sv
module eirq_irq_fsm
    import eirq_pkg::*;
#(
    parameter int unsigned N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] flag_q,
    input  logic [N_SRC-1:0] mask_q,
    output logic             irq_out
);
    irq_state_t state_q, state_d;
    logic       any_live;

    assign any_live = |(flag_q & ~mask_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (any_live)  state_d = IRQ_RAISED; // RAISE
            IRQ_RAISED: if (!any_live) state_d = IRQ_IDLE;   // DROP
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_out = (state_q == IRQ_RAISED);
    end

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        any_live |=> irq_out); // R7
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !any_live |=> !irq_out); // R6
endmodule

// File: rtl/edge_flag_irq_ctrl.sv
module edge_flag_irq_ctrl
    import eirq_pkg::*;
#(
    parameter int unsigned       N_SRC    = DEF_SRC,
    parameter int unsigned       ADDR_W   = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] FLAG_OFS = 4'h2,
    parameter logic [ADDR_W-1:0] MASK_OFS = 4'hA,
    parameter logic [N_SRC-1:0]  MASK_RST = 16'h0700
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [N_SRC-1:0]  bus_wdata,
    output logic [N_SRC-1:0]  bus_rdata,
    output logic              irq_out
);
    logic [N_SRC-1:0] rise_pulse, flag_q, mask_q;

    eirq_edge_sync #(.N_SRC(N_SRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .rise_pulse(rise_pulse)
    );

    eirq_regfile #(
        .N_SRC(N_SRC), .ADDR_W(ADDR_W), .FLAG_OFS(FLAG_OFS),
        .MASK_OFS(MASK_OFS), .MASK_RST(MASK_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .rise_pulse(rise_pulse),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .flag_q(flag_q), .mask_q(mask_q)
    );

    eirq_irq_fsm #(.N_SRC(N_SRC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .mask_q(mask_q),
        .irq_out(irq_out)
    );
endmodule

// File: tb/edge_flag_irq_ctrl_bench.sv
`timescale 1ns/1ps
module edge_flag_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_in = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    bit          isirq_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    edge_flag_irq_ctrl u_edge_flag_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            logic [15:0] act;
            wait (exp_q.size() != 0);
            act = isirq_q[0] ? {15'd0, irq_out} : bus_rdata;
            checks++;
            if (act !== exp_q[0]) begin
                errors++;
                $display("FAIL %s: actual 0x%04h expected 0x%04h", tag_q[0], act, exp_q[0]);
            end
            void'(exp_q.pop_front());
            void'(isirq_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rd(logic [3:0] a, logic [15:0] e, string tag);
        @(negedge clk);
        bus_addr = a;
        bus_we   = 1'b0;
        #1;
        exp_q.push_back(e); isirq_q.push_back(1'b0); tag_q.push_back(tag);
    endtask

    task automatic expect_irq(logic e, string tag);
        #1;
        exp_q.push_back({15'd0, e}); isirq_q.push_back(1'b1); tag_q.push_back(tag);
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        // R1 reset state
        expect_rd(4'h2, 16'h0000, "R1 flags");
        expect_rd(4'hA, 16'h0700, "R1 mask");
        expect_irq(1'b0, "R1 irq");
        expect_rd(4'h4, 16'h0000, "R9 unmapped read");

        // R2 rising edge sets flag, sticky
        @(negedge clk); src_in[0] = 1'b1;
        cycles(4);
        expect_rd(4'h2, 16'h0001, "R2 flag set");
        expect_irq(1'b1, "R7 irq high");
        @(negedge clk); src_in[0] = 1'b0;
        cycles(4);
        expect_rd(4'h2, 16'h0001, "R2 flag sticky");

        // R3 held high and falling edge set nothing
        @(negedge clk); src_in[2] = 1'b1;
        cycles(4);
        wr(4'h2, 16'h0000);
        cycles(5);
        expect_rd(4'h2, 16'h0000, "R3 held high");
        @(negedge clk); src_in[2] = 1'b0;
        cycles(4);
        expect_rd(4'h2, 16'h0000, "R3 falling edge");
        expect_irq(1'b0, "R7 irq low");

        // R4 selective clear
        @(negedge clk); src_in[4] = 1'b1; src_in[5] = 1'b1;
        cycles(4);
        wr(4'h2, 16'hFFEF);
        expect_rd(4'h2, 16'h0020, "R4 clear bit4 keep bit5");
        @(negedge clk); src_in[4] = 1'b0; src_in[5] = 1'b0;
        wr(4'h2, 16'h0000);
        cycles(4);

        // R8 masked source latches, unmask raises irq next cycle
        @(negedge clk); src_in[8] = 1'b1;
        cycles(4);
        expect_rd(4'h2, 16'h0100, "R9 raw flag of masked source");
        expect_irq(1'b0, "R6 masked blocks irq");
        @(negedge clk);
        bus_addr = 4'hA; bus_wdata = 16'h0600; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        expect_irq(1'b0, "R7 one stage delay");
        @(negedge clk);
        expect_irq(1'b1, "R8 unmask raises irq");
        expect_rd(4'hA, 16'h0600, "R6 mask readback");
        wr(4'hA, 16'h0700);
        @(negedge clk);
        expect_irq(1'b0, "R6 remask drops irq");

        // R10 writes elsewhere ignored
        wr(4'h6, 16'h0000);
        wr(4'h3, 16'hFFFF);
        expect_rd(4'h2, 16'h0100, "R10 flags untouched");
        expect_rd(4'hA, 16'h0700, "R10 mask untouched");

        // R5 edge and clearing write in the same cycle
        @(negedge clk); src_in[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 4'h2; bus_wdata = 16'h0000; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        expect_rd(4'h2, 16'h0008, "R5 edge beats clear");
        @(negedge clk);
        expect_irq(1'b1, "R7 irq from bit3");

        // R6 all masked
        wr(4'hA, 16'hFFFF);
        @(negedge clk); src_in[12] = 1'b1;
        cycles(5);
        expect_rd(4'h2, 16'h1008, "R2 second source");
        expect_irq(1'b0, "R6 all masked");
        wr(4'h2, 16'h0000);
        wr(4'hA, 16'h0000);
        cycles(2);
        expect_irq(1'b0, "R7 nothing pending");

        cycles(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule